// File: doc/BRIEF.md
# Serial Converter Readout Master with Busy Polling

This block is the host side of a three-wire link to a 16-bit converter. The link carries a chip-select (`cs_n`), a host-driven serial clock (`sck`) and a data line from the device (`sdo`). After `start` is accepted, the block waits for the conversion to end in one of two ways. In the timed way it waits a fixed number of system clocks. In the polling way it selects the device with the clock parked high and watches the data line, which stays high while the device is busy. It then clocks in the result MSB first, presents the word with a one-cycle strobe, and frames the end of the transfer so that the device begins its next conversion.

The device changes its data line on falling clock edges and the host captures on rising edges. The next conversion is started by one of two means. The first raises chip-select after the last bit. The second produces one extra falling clock edge while the device is still selected. A pending transfer can be cut short at any time with `abort`. A busy line that never clears ends the poll with an error flag.

Top module: `adc_link_reader`

## Requirements
- R1: Out of reset `cs_n`=1, `sck`=1, `ready`=1, `result_valid`=0 and `timeout_err`=0.
- R2: `ready` is 1 only while idle, and `cs_n` is 1 whenever `ready` is 1. `start` is taken only while `ready`=1.
- R3: With `status_mode`=1, `cs_n` goes low on the cycle after `start` is taken. `sck` then stays at 1 until a half-period tick samples `sdo`=0.
- R4: If `POLL_LIMIT` consecutive half-period ticks sample `sdo`=1 while polling, the block sets `timeout_err`, raises `cs_n`, returns to idle and gives no `result_valid`.
- R5: With `status_mode`=0, `cs_n` stays high for `WAIT_CYCLES` cycles after the cycle that takes `start`, and then falls.
- R6: In timed reads, the block samples bit 15 at the first tick after `cs_n` falls and bits 14..0 on the next 15 rising `sck` edges. Each of those bits is changed by the device on the preceding falling edge.
- R7: In polled reads, the block samples bit 15 on the first rising `sck` edge after the first falling edge. It samples all 16 bits on consecutive rising edges.
- R8: Every `sck` transition while selected is a multiple of `HALF_DIV` clocks from the previous one, or from the `cs_n` fall. The shortest gap is exactly `HALF_DIV`.
- R9: Each completed read gives exactly one `result_valid` pulse, one cycle wide, with `result` equal to the device word (first bit received in `result[15]`).
- R10: With `restart_by_sck`=0, after the last bit `cs_n` rises before any further falling `sck` edge.
- R11: With `restart_by_sck`=1, after the last bit exactly one falling `sck` edge occurs while `cs_n` is low, and then `cs_n` rises.
- R12: `abort` while not idle raises `cs_n` and returns to idle on the next cycle, with no `result_valid`.
- R13: The idle `sck` level is `idle_high` in timed mode. In polled mode `sck` is held high whatever `idle_high` is.
- R14: `timeout_err` stays set until the next `start` is taken, and clears on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one read cycle (taken when ready) |
| status_mode | input | 1 | 1: poll the data line for end of conversion; 0: fixed wait |
| idle_high | input | 1 | Idle clock level in timed mode |
| restart_by_sck | input | 1 | 1: extra falling clock edge starts next conversion; 0: chip-select rise |
| abort | input | 1 | End the current transfer at once |
| sdo | input | 1 | Serial data / busy from device |
| ready | output | 1 | Idle and able to take start |
| cs_n | output | 1 | Active-low device select |
| sck | output | 1 | Serial clock to device |
| result | output | DATA_W | Last word read |
| result_valid | output | 1 | One-cycle strobe for a new result |
| timeout_err | output | 1 | Busy poll exceeded its limit |

## Verification
The hardest case to reach is the end of a polled read. The device must turn from busy to ready while it is still selected. The bench must then see the first data bit come only after the first falling edge, not at the select edge. The device model in the bench holds a busy countdown that runs out while `cs_n` is low and then drives the line low. From that point it shifts its word one bit per falling edge. This lets the bench compare the captured word and the single extra falling edge or chip-select rise against the model's own count of conversion triggers. The stuck-busy case comes from making the countdown longer than the poll limit.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_POLL,
    ST_SETUP,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_END,
    ST_TAIL
  } link_state_t;

  // clock level parked between transfers
  function automatic logic park_level(input logic poll_mode, input logic want_high);
    return poll_mode | want_high;
  endfunction

  // width of a counter that must reach lim-1
  function automatic int count_width(input int lim);
    return (lim > 2) ? $clog2(lim) : 1;
  endfunction

endpackage

// File: rtl/link_limit_counter.sv
module link_limit_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  output logic hit
);
  localparam int CW = adc_link_pkg::count_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit = en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (hit)   cnt_q <= '0;
    else if (en)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/link_bit_shifter.sv
module link_bit_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] word_next,
  output logic              last_bit
);
  localparam int NW = $clog2(DATA_W + 1);
  localparam logic [NW-1:0] FINAL = NW'(DATA_W - 1);

  logic [DATA_W-1:0] word_q;
  logic [NW-1:0]     got_q;

  assign word_next = {word_q[DATA_W-2:0], bit_in};
  assign last_bit  = (got_q == FINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      got_q  <= '0;
    end else if (clear) begin
      word_q <= '0;
      got_q  <= '0;
    end else if (shift_en) begin
      word_q <= word_next;
      got_q  <= got_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_link_reader.sv
module adc_link_reader
  import adc_link_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int HALF_DIV    = 625,
  parameter int WAIT_CYCLES = 5_250_000,
  parameter int POLL_LIMIT  = 10_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              status_mode,
  input  logic              idle_high,
  input  logic              restart_by_sck,
  input  logic              abort,
  input  logic              sdo,
  output logic              ready,
  output logic              cs_n,
  output logic              sck,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              timeout_err
);

  link_state_t       state_q;
  logic              cs_q, sck_q, err_q, valid_q;
  logic [DATA_W-1:0] result_q;
  logic              cfg_idle_hi, cfg_by_sck;

  // named internal events
  logic tick, wait_done, poll_expired, poll_active, capture, last_capture;
  logic take_start, abort_now;
  logic [DATA_W-1:0] word_next;
  logic last_bit;

  assign ready       = (state_q == ST_IDLE);
  assign poll_active = (state_q == ST_POLL);
  assign take_start  = ready && start;
  assign abort_now   = !ready && abort;
  assign capture     = tick && !abort_now &&
                       ((state_q == ST_SETUP) || (state_q == ST_LOW));
  assign last_capture = capture && last_bit;

  link_limit_counter #(.LIMIT(HALF_DIV)) u_half (
    .clk(clk), .rst_n(rst_n),
    .clear(state_q == ST_IDLE || state_q == ST_WAIT),
    .en(1'b1), .hit(tick)
  );

  link_limit_counter #(.LIMIT(WAIT_CYCLES)) u_wait (
    .clk(clk), .rst_n(rst_n),
    .clear(state_q != ST_WAIT),
    .en(1'b1), .hit(wait_done)
  );

  link_limit_counter #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n),
    .clear(state_q != ST_POLL),
    .en(tick && sdo), .hit(poll_expired)
  );

  link_bit_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .clear(take_start), .shift_en(capture), .bit_in(sdo),
    .word_next(word_next), .last_bit(last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cs_q        <= 1'b1;
      sck_q       <= 1'b1;
      err_q       <= 1'b0;
      valid_q     <= 1'b0;
      result_q    <= '0;
      cfg_idle_hi <= 1'b1;
      cfg_by_sck  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (abort_now) begin
        cs_q    <= 1'b1;
        sck_q   <= cfg_idle_hi;
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            cs_q  <= 1'b1;
            sck_q <= park_level(status_mode, idle_high);
            if (start) begin
              cfg_idle_hi <= park_level(status_mode, idle_high);
              cfg_by_sck  <= restart_by_sck;
              err_q       <= 1'b0;
              if (status_mode) begin
                cs_q    <= 1'b0;
                sck_q   <= 1'b1;
                state_q <= ST_POLL;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          ST_WAIT: if (wait_done) begin
            cs_q    <= 1'b0;
            state_q <= ST_SETUP;
          end
          ST_POLL: if (tick) begin
            if (!sdo) begin
              sck_q   <= 1'b0;
              state_q <= ST_LOW;
            end else if (poll_expired) begin
              err_q   <= 1'b1;
              cs_q    <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          ST_SETUP: if (tick) begin
            if (cfg_idle_hi) begin
              sck_q   <= 1'b0;
              state_q <= ST_LOW;
            end else begin
              sck_q   <= 1'b1;
              state_q <= ST_LEAD;
            end
          end
          ST_LEAD: if (tick) begin
            sck_q   <= 1'b0;
            state_q <= ST_LOW;
          end
          ST_LOW: if (tick) begin
            sck_q <= 1'b1;
            if (last_capture) begin
              result_q <= word_next;
              valid_q  <= 1'b1;
              state_q  <= ST_END;
            end else begin
              state_q  <= ST_HIGH;
            end
          end
          ST_HIGH: if (tick) begin
            sck_q   <= 1'b0;
            state_q <= ST_LOW;
          end
          ST_END: if (tick) begin
            if (cfg_by_sck) sck_q <= 1'b0;
            else            cs_q  <= 1'b1;
            state_q <= ST_TAIL;
          end
          ST_TAIL: if (tick) begin
            sck_q   <= cfg_idle_hi;
            cs_q    <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign cs_n         = cs_q;
  assign sck          = sck_q;
  assign result       = result_q;
  assign result_valid = valid_q;
  assign timeout_err  = err_q;

endmodule

// File: rtl/adc_link_reader_chk.sv
module adc_link_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic cs_n,
  input logic sck,
  input logic result_valid,
  input logic timeout_err,
  input logic abort,
  input logic tick,
  input logic poll_active
);

  // R2
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cs_n);

  // R3
  poll_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_active |-> (sck && !cs_n));

  // R4
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (ready && cs_n && !result_valid));

  // R8
  sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sck) && !$past(ready) && !$past(abort)) |-> $past(tick));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R12
  abort_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort && !ready) |-> (cs_n && ready && !result_valid));

endmodule

bind adc_link_reader adc_link_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .cs_n(cs_n), .sck(sck),
  .result_valid(result_valid), .timeout_err(timeout_err), .abort(abort),
  .tick(tick), .poll_active(poll_active)
);

// File: tb/sim_adc_link_reader.sv
`timescale 1ns/1ps
module sim_adc_link_reader;
  localparam int HD = 4;
  localparam int WC = 40;
  localparam int PL = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, status_mode = 0, idle_high = 1, restart_by_sck = 0, abort = 0;
  logic sdo = 1'b1;
  logic ready, cs_n, sck, result_valid, timeout_err;
  logic [15:0] result;

  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  adc_link_reader #(.DATA_W(16), .HALF_DIV(HD), .WAIT_CYCLES(WC), .POLL_LIMIT(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .status_mode(status_mode),
    .idle_high(idle_high), .restart_by_sck(restart_by_sck), .abort(abort),
    .sdo(sdo), .ready(ready), .cs_n(cs_n), .sck(sck), .result(result),
    .result_valid(result_valid), .timeout_err(timeout_err));

  // device model and link monitor, all at falling system clock edges
  logic [15:0] dev_word = 16'h0;
  int  dev_ptr = -2;      // -2 idle, 17 busy, 16 ready-pre, 15..0 bit, -1 triggered
  bit  dev_busy = 0;
  int  busy_left = 0;
  int  triggers = 0, trig_src = 0, tail_falls = 0;
  int  valid_cnt = 0, valid_wide = 0, poll_bad = 0;
  int  last_edge = 0, min_gap = 1 << 30, bad_gap = 0, setup_gap = 0;
  bit  first_edge = 0;
  logic prev_cs = 1'b1, prev_sck = 1'b1, prev_valid = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (dev_busy) begin
      if (busy_left == 0) dev_busy = 0; else busy_left--;
    end
    if (cs_n && !prev_cs) begin
      if (dev_ptr >= 0 && dev_ptr <= 16) begin triggers++; trig_src = 1; dev_ptr = -1; end
      dev_ptr = -2; sdo = 1'b1;
    end else if (!cs_n && prev_cs) begin
      last_edge = cyc; first_edge = 1;
      if (dev_busy) begin dev_ptr = 17; sdo = 1'b1; end
      else begin dev_ptr = 15; sdo = dev_word[15]; end
    end else if (!cs_n) begin
      if (sck != prev_sck) begin
        if ((cyc - last_edge) % HD != 0) bad_gap++;
        if (first_edge) begin setup_gap = cyc - last_edge; first_edge = 0; end
        else if (cyc - last_edge < min_gap) min_gap = cyc - last_edge;
        last_edge = cyc;
      end
      if (dev_ptr == 17 && !sck) poll_bad++;
      if (dev_ptr == 17 && !dev_busy) begin dev_ptr = 16; sdo = 1'b0; end
      else if (!sck && prev_sck) begin
        if (dev_ptr == 16) begin dev_ptr = 15; sdo = dev_word[15]; end
        else if (dev_ptr > 0 && dev_ptr <= 15) begin dev_ptr--; sdo = dev_word[dev_ptr]; end
        else if (dev_ptr == 0) begin triggers++; trig_src = 2; dev_ptr = -1; end
        else if (dev_ptr == -1) tail_falls++;
      end
    end
    if (result_valid) valid_cnt++;
    if (result_valid && prev_valid) valid_wide++;
    prev_valid = result_valid; prev_cs = cs_n; prev_sck = sck;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    triggers = 0; trig_src = 0; tail_falls = 0; valid_cnt = 0; valid_wide = 0;
    poll_bad = 0; min_gap = 1 << 30; bad_gap = 0; setup_gap = 0;
  endtask

  task automatic wait_ready(input int limit);
    for (int i = 0; i < limit && !ready; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic t_reset();
    chk(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
    chk(sck == 1'b1, "R1", "sck", sck, 1);
    chk(ready == 1'b1, "R1", "ready", ready, 1);
    chk(result_valid == 1'b0, "R1", "valid", result_valid, 0);
    chk(timeout_err == 1'b0, "R1", "err", timeout_err, 0);
  endtask

  task automatic t_timed(input logic [15:0] w, input logic ih, input logic by_sck);
    int n;
    clear_mon();
    dev_word = w; dev_busy = 0;
    status_mode = 0; idle_high = ih; restart_by_sck = by_sck;
    @(negedge clk);
    chk(sck == ih, "R13", "timed idle level", sck, ih);
    pulse_start();
    chk(ready == 1'b0, "R2", "ready after start", ready, 0);
    chk(timeout_err == 1'b0, "R14", "err cleared by start", timeout_err, 0);
    n = 1;
    while (cs_n && n < 10 * WC) begin @(negedge clk); n++; end
    chk(n == WC + 1, "R5", "cycles to cs fall", n, WC + 1);
    wait_ready(4000);
    chk(valid_cnt == 1, "R9", "valid pulses", valid_cnt, 1);
    chk(valid_wide == 0, "R9", "valid width", valid_wide, 0);
    chk(result == w, "R6", "timed word", result, w);
    chk(triggers == 1 && trig_src == (by_sck ? 2 : 1),
        by_sck ? "R11" : "R10", "restart source", trig_src, by_sck ? 2 : 1);
    chk(tail_falls == 0, by_sck ? "R11" : "R10", "extra falls", tail_falls, 0);
    chk(bad_gap == 0 && min_gap == HD, "R8", "min sck gap", min_gap, HD);
    chk(setup_gap >= HD, "R8", "cs setup", setup_gap, HD);
    @(negedge clk);
    chk(sck == ih, "R13", "idle level after read", sck, ih);
  endtask

  task automatic t_status(input logic [15:0] w, input logic ih_in, input int busy, input logic by_sck);
    clear_mon();
    dev_word = w; dev_busy = 1; busy_left = busy;
    status_mode = 1; idle_high = ih_in; restart_by_sck = by_sck;
    @(negedge clk);
    chk(sck == 1'b1, "R13", "poll idle forced high", sck, 1);
    pulse_start();
    chk(cs_n == 1'b0 && sck == 1'b1, "R3", "select with sck high", {cs_n, sck}, 2'b01);
    wait_ready(4000);
    chk(poll_bad == 0, "R3", "sck low while busy", poll_bad, 0);
    chk(result == w && valid_cnt == 1, "R7", "polled word", result, w);
    chk(triggers == 1 && trig_src == (by_sck ? 2 : 1),
        by_sck ? "R11" : "R10", "restart source", trig_src, by_sck ? 2 : 1);
    chk(timeout_err == 1'b0, "R4", "no error when ready", timeout_err, 0);
    @(negedge clk);
    chk(sck == 1'b1, "R13", "parked high after poll", sck, 1);
  endtask

  task automatic t_timeout();
    clear_mon();
    dev_busy = 1; busy_left = 100000;
    status_mode = 1; idle_high = 0; restart_by_sck = 0;
    pulse_start();
    wait_ready(4000);
    chk(timeout_err == 1'b1, "R4", "error flag", timeout_err, 1);
    chk(cs_n == 1'b1, "R4", "deselected", cs_n, 1);
    chk(valid_cnt == 0, "R4", "no valid", valid_cnt, 0);
    chk(poll_bad == 0, "R3", "sck parked during poll", poll_bad, 0);
    repeat (5) @(negedge clk);
    chk(timeout_err == 1'b1, "R14", "error held", timeout_err, 1);
    dev_busy = 0; busy_left = 0;
  endtask

  task automatic t_abort();
    clear_mon();
    dev_word = 16'h3C3C; dev_busy = 0;
    status_mode = 0; idle_high = 1; restart_by_sck = 1;
    pulse_start();
    while (cs_n) @(negedge clk);
    repeat (6 * HD) @(negedge clk);
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    chk(cs_n == 1'b1 && ready == 1'b1, "R12", "abort exit", {cs_n, ready}, 2'b11);
    repeat (20 * HD) @(negedge clk);
    chk(valid_cnt == 0, "R12", "no valid on abort", valid_cnt, 0);
    chk(triggers == 1 && trig_src == 1, "R12", "abort restarts via cs", trig_src, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_timed(16'hA5C3, 1'b1, 1'b0);
    t_timed(16'h0001, 1'b0, 1'b1);
    t_timed(16'hFFFF, 1'b1, 1'b1);
    t_timed(16'h8000, 1'b0, 1'b0);
    t_status(16'h7FFE, 1'b1, 30, 1'b0);
    t_status(16'h0000, 1'b0, 3, 1'b1);
    t_timeout();
    t_timed(16'h1234, 1'b1, 1'b0);   // R14 clear checked inside
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule